// File: doc/BRIEF.md
# Integer Execution Unit with Single-Entry Reservation Station

This block is a 32-bit integer execution unit with a one-entry reservation station in front of it. Dispatch hands it one instruction at a time. Each instruction carries an opcode, a destination rename tag and two source operands. A source either arrives with its value already read from the register file, or carries a rename tag. A tagged source is filled by snooping the result buses: when a bus broadcasts a matching tag, the station takes that bus's value.

When both sources hold values, the instruction issues to exactly one of three single-cycle subunits:
- an adder/comparator,
- a logical unit,
- a shift/rotate/count-leading-zeros unit.

The result is registered and driven on the unit's own result bus, together with the destination tag.

The parameter `HAS_MULDIV` picks the variant:
- **Full variant:** accepts multiply and divide. It does not compute them; it hands them to an external multiplier/divider port.
- **Restricted variant:** refuses multiply and divide. It raises an illegal-dispatch pulse and produces no result.

Top module: `int_exec_unit`

## Requirements
- R1: While `rst_ni` is low and in the first cycle after release, `disp_ready_o` is high and `res_valid_o`, `illegal_o` and `md_valid_o` are low.
- R2: The station holds at most one instruction. `disp_ready_o` is low from the edge that accepts an instruction until the edge at which it issues, and a dispatch held valid meanwhile is taken at the first edge after issue.
- R3: A source waiting on a tag takes its value from any snoop bus whose valid is high and whose tag matches. This includes a broadcast in the same cycle as dispatch. If several buses match, the lowest-numbered bus wins; a source already marked ready ignores the buses.
- R4: An instruction issues in the first cycle both sources hold values. Its result appears on `res_valid_o`/`res_tag_o`/`res_val_o` one cycle later, for one cycle, with the destination tag. At most one subunit is active in any cycle.
- R5: Opcodes 0 add, 1 subtract (a minus b) and 2 compare. Compare returns a word with bit0 equal, bit1 signed less, bit2 signed greater, bit3 unsigned less and bit4 unsigned greater; all other bits are zero.
- R6: Opcodes 3 AND, 4 OR, 5 XOR and 6 NOR.
- R7: Opcodes 7 shift left, 8 logical shift right, 9 arithmetic shift right and 10 rotate left. The shift amount is b[4:0].
- R8: Opcode 11 returns the count of leading zeros of a, and 32 for a zero operand.
- R9: With `HAS_MULDIV`=0, opcode 12 (multiply) or 13 (divide) offered while ready is not accepted. `illegal_o` pulses one cycle later, no result appears, and ready stays high.
- R10: With `HAS_MULDIV`=1, opcodes 12 and 13 are accepted. On issue they pulse `md_valid_o` one cycle later with the tag, `md_div_o` (1 for divide) and both operands, and never drive `res_valid_o`.
- R11: Opcodes 14 and 15 are refused in both variants, with an `illegal_o` pulse one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | 1 | Dispatch offers an instruction |
| disp_ready_o | output | 1 | Station is empty and can take an instruction |
| disp_op_i | input | 4 | Opcode |
| disp_dst_i | input | TAG_W | Destination rename tag |
| disp_a_rdy_i | input | 1 | Source a value is valid |
| disp_a_tag_i | input | TAG_W | Source a tag to wait on |
| disp_a_val_i | input | XLEN | Source a value |
| disp_b_rdy_i | input | 1 | Source b value is valid |
| disp_b_tag_i | input | TAG_W | Source b tag to wait on |
| disp_b_val_i | input | XLEN | Source b value |
| snp_valid_i | input | NUM_BUS | Per-bus broadcast valid |
| snp_tag_i | input | NUM_BUS*TAG_W | Per-bus broadcast tags, bus 0 in the low bits |
| snp_val_i | input | NUM_BUS*XLEN | Per-bus broadcast values, bus 0 in the low bits |
| res_valid_o | output | 1 | Result bus valid |
| res_tag_o | output | TAG_W | Result tag |
| res_val_o | output | XLEN | Result value |
| md_valid_o | output | 1 | Multiply/divide hand-off valid |
| md_div_o | output | 1 | Hand-off is a divide |
| md_tag_o | output | TAG_W | Hand-off destination tag |
| md_a_o | output | XLEN | Hand-off operand a |
| md_b_o | output | XLEN | Hand-off operand b |
| illegal_o | output | 1 | Refused dispatch pulse |

## Verification
The bench drives two instances with identical stimulus, one of each variant, and compares them every cycle against a behavioural model.

Each of opcodes 0 to 11 is tried on six operand pairs, chosen to tell the cases apart:
- zero with zero, which isolates the count-leading-zeros result of 32;
- all-ones with one, which separates signed from unsigned compare;
- the sign bit with shift amount 31, which separates arithmetic from logical shift and rotate from shift;
- the amount taken from b[4:0] rather than the full word;
- ordinary mixed values.

Directed snoop cases cover the tag-matching paths:
- a late broadcast next to a non-matching one;
- a broadcast in the dispatch cycle;
- two buses matching the same tag.

These tell a captured value from a stale one and show the bus priority. A dispatch held during a pending wait shows the one-entry back-pressure. A randomised run with random readiness, tags and opcodes 0 to 15 then mixes all of these.

// File: rtl/int_eu_pkg.sv
package int_eu_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_CMP  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_NOR  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9,
    OP_ROTL = 4'd10,
    OP_CLZ  = 4'd11,
    OP_MUL  = 4'd12,
    OP_DIV  = 4'd13
  } op_e;

  localparam int SU_N   = 3;
  localparam int SU_ADD = 0;
  localparam int SU_LOG = 1;
  localparam int SU_SHF = 2;

  // compare result bit positions
  localparam int FLG_EQ  = 0;
  localparam int FLG_LTS = 1;
  localparam int FLG_GTS = 2;
  localparam int FLG_LTU = 3;
  localparam int FLG_GTU = 4;

  function automatic logic op_defined(logic [OP_W-1:0] op);
    return op <= OP_DIV;
  endfunction

  function automatic logic is_muldiv(logic [OP_W-1:0] op);
    return (op == OP_MUL) || (op == OP_DIV);
  endfunction

  function automatic logic [SU_N-1:0] op_subunit(logic [OP_W-1:0] op);
    logic [SU_N-1:0] s;
    s = '0;
    case (op)
      OP_ADD, OP_SUB, OP_CMP:          s[SU_ADD] = 1'b1;
      OP_AND, OP_OR, OP_XOR, OP_NOR:   s[SU_LOG] = 1'b1;
      OP_SLL, OP_SRL, OP_SRA, OP_ROTL,
      OP_CLZ:                          s[SU_SHF] = 1'b1;
      default:                         s = '0;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/int_eu_station.sv
module int_eu_station
  import int_eu_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int TAG_W   = 6,
  parameter int NUM_BUS = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     acc_i,
  input  logic [OP_W-1:0]          op_i,
  input  logic [TAG_W-1:0]         dst_i,
  input  logic                     a_rdy_i,
  input  logic [TAG_W-1:0]         a_tag_i,
  input  logic [XLEN-1:0]          a_val_i,
  input  logic                     b_rdy_i,
  input  logic [TAG_W-1:0]         b_tag_i,
  input  logic [XLEN-1:0]          b_val_i,
  input  logic [NUM_BUS-1:0]       snp_valid_i,
  input  logic [NUM_BUS*TAG_W-1:0] snp_tag_i,
  input  logic [NUM_BUS*XLEN-1:0]  snp_val_i,
  output logic                     busy_o,
  output logic                     iss_o,
  output logic [OP_W-1:0]          iss_op_o,
  output logic [TAG_W-1:0]         iss_tag_o,
  output logic [XLEN-1:0]          iss_a_o,
  output logic [XLEN-1:0]          iss_b_o
);

  localparam int N_SRC = 2;
  localparam int N_LK  = 2 * N_SRC;  // dispatch lookups then held lookups

  logic                 busy_q;
  logic [OP_W-1:0]      op_q;
  logic [TAG_W-1:0]     dst_q;
  logic                 rdy_q [N_SRC];
  logic [TAG_W-1:0]     tag_q [N_SRC];
  logic [XLEN-1:0]      val_q [N_SRC];

  logic                 d_rdy [N_SRC];
  logic [TAG_W-1:0]     d_tag [N_SRC];
  logic [XLEN-1:0]      d_val [N_SRC];

  logic [TAG_W-1:0]     lk_tag [N_LK];
  logic [NUM_BUS-1:0]   lk_hits [N_LK];
  logic                 lk_hit [N_LK];
  logic [XLEN-1:0]      lk_val [N_LK];

  assign d_rdy[0] = a_rdy_i;
  assign d_tag[0] = a_tag_i;
  assign d_val[0] = a_val_i;
  assign d_rdy[1] = b_rdy_i;
  assign d_tag[1] = b_tag_i;
  assign d_val[1] = b_val_i;

  for (genvar j = 0; j < N_SRC; j++) begin : g_lk_tag
    assign lk_tag[j]         = d_tag[j];
    assign lk_tag[N_SRC + j] = tag_q[j];
  end

  for (genvar k = 0; k < N_LK; k++) begin : g_lk
    for (genvar i = 0; i < NUM_BUS; i++) begin : g_bus
      assign lk_hits[k][i] = snp_valid_i[i] && (snp_tag_i[i*TAG_W +: TAG_W] == lk_tag[k]);
    end
    assign lk_hit[k] = |lk_hits[k];
    // lowest bus index wins
    always_comb begin
      lk_val[k] = '0;
      for (int i = NUM_BUS - 1; i >= 0; i--) begin
        if (lk_hits[k][i]) lk_val[k] = snp_val_i[i*XLEN +: XLEN];
      end
    end
  end

  assign iss_o = busy_q && rdy_q[0] && rdy_q[1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= '0;
      dst_q  <= '0;
    end else if (acc_i) begin
      busy_q <= 1'b1;
      op_q   <= op_i;
      dst_q  <= dst_i;
    end else if (iss_o) begin
      busy_q <= 1'b0;
    end
  end

  for (genvar j = 0; j < N_SRC; j++) begin : g_src
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rdy_q[j] <= 1'b0;
        tag_q[j] <= '0;
        val_q[j] <= '0;
      end else if (acc_i) begin
        rdy_q[j] <= d_rdy[j] || lk_hit[j];
        tag_q[j] <= d_tag[j];
        val_q[j] <= d_rdy[j] ? d_val[j] : lk_val[j];
      end else if (busy_q && !rdy_q[j] && lk_hit[N_SRC + j]) begin
        rdy_q[j] <= 1'b1;
        val_q[j] <= lk_val[N_SRC + j];
      end
    end
  end

  assign busy_o    = busy_q;
  assign iss_op_o  = op_q;
  assign iss_tag_o = dst_q;
  assign iss_a_o   = val_q[0];
  assign iss_b_o   = val_q[1];

endmodule

// File: rtl/int_eu_addcmp.sv
module int_eu_addcmp
  import int_eu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            en_i,
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    res_o = '0;
    if (en_i) begin
      case (op_i)
        OP_ADD: res_o = a_i + b_i;
        OP_SUB: res_o = a_i - b_i;
        OP_CMP: begin
          res_o[FLG_EQ]  = (a_i == b_i);
          res_o[FLG_LTS] = ($signed(a_i) < $signed(b_i));
          res_o[FLG_GTS] = ($signed(a_i) > $signed(b_i));
          res_o[FLG_LTU] = (a_i < b_i);
          res_o[FLG_GTU] = (a_i > b_i);
        end
        default: res_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/int_eu_logic.sv
module int_eu_logic
  import int_eu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            en_i,
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    res_o = '0;
    if (en_i) begin
      case (op_i)
        OP_AND:  res_o = a_i & b_i;
        OP_OR:   res_o = a_i | b_i;
        OP_XOR:  res_o = a_i ^ b_i;
        OP_NOR:  res_o = ~(a_i | b_i);
        default: res_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/int_eu_shift.sv
module int_eu_shift
  import int_eu_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            en_i,
  input  op_e             op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] res_o
);

  localparam int SH_W  = $clog2(XLEN);
  localparam int CNT_W = $clog2(XLEN + 1);

  logic [SH_W-1:0]   sh;
  logic [2*XLEN-1:0] rot_w;
  logic [CNT_W-1:0]  clz;
  logic              unused_b;

  assign sh       = b_i[SH_W-1:0];
  assign unused_b = ^b_i[XLEN-1:SH_W];
  assign rot_w    = {a_i, a_i} << sh;

  always_comb begin
    clz = CNT_W'(XLEN);
    for (int i = 0; i < XLEN; i++) begin
      if (a_i[i]) clz = CNT_W'(XLEN - 1 - i);
    end
  end

  always_comb begin
    res_o = '0;
    if (en_i) begin
      case (op_i)
        OP_SLL:  res_o = a_i << sh;
        OP_SRL:  res_o = a_i >> sh;
        OP_SRA:  res_o = $unsigned($signed(a_i) >>> sh);
        OP_ROTL: res_o = rot_w[2*XLEN-1:XLEN];
        OP_CLZ:  res_o = {{(XLEN-CNT_W){1'b0}}, clz};
        default: res_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import int_eu_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int TAG_W      = 6,
  parameter int NUM_BUS    = 2,
  parameter int HAS_MULDIV = 1
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     disp_valid_i,
  output logic                     disp_ready_o,
  input  logic [3:0]               disp_op_i,
  input  logic [TAG_W-1:0]         disp_dst_i,
  input  logic                     disp_a_rdy_i,
  input  logic [TAG_W-1:0]         disp_a_tag_i,
  input  logic [XLEN-1:0]          disp_a_val_i,
  input  logic                     disp_b_rdy_i,
  input  logic [TAG_W-1:0]         disp_b_tag_i,
  input  logic [XLEN-1:0]          disp_b_val_i,
  input  logic [NUM_BUS-1:0]       snp_valid_i,
  input  logic [NUM_BUS*TAG_W-1:0] snp_tag_i,
  input  logic [NUM_BUS*XLEN-1:0]  snp_val_i,
  output logic                     res_valid_o,
  output logic [TAG_W-1:0]         res_tag_o,
  output logic [XLEN-1:0]          res_val_o,
  output logic                     md_valid_o,
  output logic                     md_div_o,
  output logic [TAG_W-1:0]         md_tag_o,
  output logic [XLEN-1:0]          md_a_o,
  output logic [XLEN-1:0]          md_b_o,
  output logic                     illegal_o
);

  logic             busy, offer, legal, acc;
  logic             iss;
  logic [OP_W-1:0]  iss_op;
  logic [TAG_W-1:0] iss_tag;
  logic [XLEN-1:0]  iss_a, iss_b;
  logic [SU_N-1:0]  sub_sel;
  logic [XLEN-1:0]  sub_res [SU_N];
  logic [XLEN-1:0]  exe_res;
  op_e              exe_op;

  assign legal = op_defined(disp_op_i) && ((HAS_MULDIV != 0) || !is_muldiv(disp_op_i));
  assign offer = disp_valid_i && !busy;
  assign acc   = offer && legal;

  int_eu_station #(
    .XLEN(XLEN), .TAG_W(TAG_W), .NUM_BUS(NUM_BUS)
  ) u_stn (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .acc_i       (acc),
    .op_i        (disp_op_i),
    .dst_i       (disp_dst_i),
    .a_rdy_i     (disp_a_rdy_i),
    .a_tag_i     (disp_a_tag_i),
    .a_val_i     (disp_a_val_i),
    .b_rdy_i     (disp_b_rdy_i),
    .b_tag_i     (disp_b_tag_i),
    .b_val_i     (disp_b_val_i),
    .snp_valid_i (snp_valid_i),
    .snp_tag_i   (snp_tag_i),
    .snp_val_i   (snp_val_i),
    .busy_o      (busy),
    .iss_o       (iss),
    .iss_op_o    (iss_op),
    .iss_tag_o   (iss_tag),
    .iss_a_o     (iss_a),
    .iss_b_o     (iss_b)
  );

  assign exe_op  = op_e'(iss_op);
  assign sub_sel = iss ? op_subunit(iss_op) : '0;

  int_eu_addcmp #(.XLEN(XLEN)) u_add (
    .en_i(sub_sel[SU_ADD]), .op_i(exe_op), .a_i(iss_a), .b_i(iss_b), .res_o(sub_res[SU_ADD])
  );
  int_eu_logic #(.XLEN(XLEN)) u_log (
    .en_i(sub_sel[SU_LOG]), .op_i(exe_op), .a_i(iss_a), .b_i(iss_b), .res_o(sub_res[SU_LOG])
  );
  int_eu_shift #(.XLEN(XLEN)) u_shf (
    .en_i(sub_sel[SU_SHF]), .op_i(exe_op), .a_i(iss_a), .b_i(iss_b), .res_o(sub_res[SU_SHF])
  );

  // disabled subunits drive zero
  always_comb begin
    exe_res = '0;
    for (int s = 0; s < SU_N; s++) exe_res |= sub_res[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_tag_o   <= '0;
      res_val_o   <= '0;
      md_valid_o  <= 1'b0;
      md_div_o    <= 1'b0;
      md_tag_o    <= '0;
      md_a_o      <= '0;
      md_b_o      <= '0;
      illegal_o   <= 1'b0;
    end else begin
      res_valid_o <= iss && !is_muldiv(iss_op);
      md_valid_o  <= iss && is_muldiv(iss_op);
      illegal_o   <= offer && !legal;
      if (iss) begin
        res_tag_o <= iss_tag;
        res_val_o <= exe_res;
        md_div_o  <= (iss_op == OP_DIV);
        md_tag_o  <= iss_tag;
        md_a_o    <= iss_a;
        md_b_o    <= iss_b;
      end
    end
  end

  assign disp_ready_o = !busy;

endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk #(
  parameter int TAG_W      = 6,
  parameter int HAS_MULDIV = 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disp_valid_i,
  input logic             disp_ready_o,
  input logic [3:0]       disp_op_i,
  input logic             res_valid_o,
  input logic [TAG_W-1:0] res_tag_o,
  input logic             md_valid_o,
  input logic             illegal_o,
  input logic             acc_i,
  input logic             iss_i,
  input logic [TAG_W-1:0] iss_tag_i,
  input logic [2:0]       sel_i
);

  p_busy_after_acc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_i |=> !disp_ready_o);

  p_free_after_iss_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_i |=> disp_ready_o);

  p_out_after_iss_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    iss_i |=> (res_valid_o || md_valid_o));

  p_res_tag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_i && !(iss_tag_i == res_tag_o)) |=> (res_valid_o || md_valid_o) && (res_tag_o == $past(iss_tag_i)));

  p_one_subunit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sel_i));

  p_no_out_idle_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !iss_i |=> !res_valid_o && !md_valid_o);

  p_md_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(res_valid_o && md_valid_o));

  p_reject_md_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (HAS_MULDIV == 0 && disp_valid_i && disp_ready_o && (disp_op_i == 4'd12 || disp_op_i == 4'd13))
      |=> illegal_o && disp_ready_o);

  p_reject_undef_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disp_valid_i && disp_ready_o && disp_op_i >= 4'd14) |=> illegal_o && disp_ready_o);

endmodule

bind int_exec_unit int_exec_unit_chk #(.TAG_W(TAG_W), .HAS_MULDIV(HAS_MULDIV)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .disp_valid_i (disp_valid_i),
  .disp_ready_o (disp_ready_o),
  .disp_op_i    (disp_op_i),
  .res_valid_o  (res_valid_o),
  .res_tag_o    (res_tag_o),
  .md_valid_o   (md_valid_o),
  .illegal_o    (illegal_o),
  .acc_i        (acc),
  .iss_i        (iss),
  .iss_tag_i    (iss_tag),
  .sel_i        (sub_sel)
);

// File: tb/int_exec_unit_tb_top.sv
module int_exec_unit_tb_top;

  localparam int XW = 32;
  localparam int TW = 6;
  localparam int NB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]       dv = '0;
  logic [3:0]       op = '0;
  logic [TW-1:0]    dst = '0;
  logic             ardy = 1'b0, brdy = 1'b0;
  logic [TW-1:0]    atag = '0, btag = '0;
  logic [XW-1:0]    aval = '0, bval = '0;
  logic [NB-1:0]    snp_v = '0;
  logic [NB*TW-1:0] snp_tag = '0;
  logic [NB*XW-1:0] snp_val = '0;

  logic          rdy [2];
  logic          rv [2];
  logic [TW-1:0] rtag [2];
  logic [XW-1:0] rval [2];
  logic          mdv [2];
  logic          mdd [2];
  logic [TW-1:0] mdt [2];
  logic [XW-1:0] mda [2];
  logic [XW-1:0] mdb [2];
  logic          ill [2];

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  int_exec_unit #(.XLEN(XW), .TAG_W(TW), .NUM_BUS(NB), .HAS_MULDIV(1)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .disp_valid_i(dv[0]), .disp_ready_o(rdy[0]),
    .disp_op_i(op), .disp_dst_i(dst),
    .disp_a_rdy_i(ardy), .disp_a_tag_i(atag), .disp_a_val_i(aval),
    .disp_b_rdy_i(brdy), .disp_b_tag_i(btag), .disp_b_val_i(bval),
    .snp_valid_i(snp_v), .snp_tag_i(snp_tag), .snp_val_i(snp_val),
    .res_valid_o(rv[0]), .res_tag_o(rtag[0]), .res_val_o(rval[0]),
    .md_valid_o(mdv[0]), .md_div_o(mdd[0]), .md_tag_o(mdt[0]), .md_a_o(mda[0]), .md_b_o(mdb[0]),
    .illegal_o(ill[0])
  );

  int_exec_unit #(.XLEN(XW), .TAG_W(TW), .NUM_BUS(NB), .HAS_MULDIV(0)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .disp_valid_i(dv[1]), .disp_ready_o(rdy[1]),
    .disp_op_i(op), .disp_dst_i(dst),
    .disp_a_rdy_i(ardy), .disp_a_tag_i(atag), .disp_a_val_i(aval),
    .disp_b_rdy_i(brdy), .disp_b_tag_i(btag), .disp_b_val_i(bval),
    .snp_valid_i(snp_v), .snp_tag_i(snp_tag), .snp_val_i(snp_val),
    .res_valid_o(rv[1]), .res_tag_o(rtag[1]), .res_val_o(rval[1]),
    .md_valid_o(mdv[1]), .md_div_o(mdd[1]), .md_tag_o(mdt[1]), .md_a_o(mda[1]), .md_b_o(mdb[1]),
    .illegal_o(ill[1])
  );

  // ---------------- behavioural reference model ----------------
  logic          m_busy [2];
  logic [3:0]    m_op [2];
  logic [TW-1:0] m_dst [2];
  logic          m_ardy [2], m_brdy [2];
  logic [TW-1:0] m_atag [2], m_btag [2];
  logic [XW-1:0] m_a [2], m_b [2];
  logic          m_snp [2];
  logic          e_rv [2], e_ill [2], e_md [2], e_mdd [2];
  logic [TW-1:0] e_tag [2];
  logic [XW-1:0] e_val [2], e_mda [2], e_mdb [2];
  string         e_req [2];
  string         e_ill_req [2];
  int            done_cnt [2];

  function automatic logic [XW:0] look(input logic [TW-1:0] t);
    logic [XW:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--)
      if (snp_v[i] && snp_tag[i*TW +: TW] == t) r = {1'b1, snp_val[i*XW +: XW]};
    return r;
  endfunction

  function automatic logic [XW-1:0] ref_exec(input logic [3:0] o, input logic [XW-1:0] a, input logic [XW-1:0] b);
    int s;
    logic [XW-1:0] r;
    s = int'(b[4:0]);
    r = '0;
    case (o)
      4'd0: r = a + b;
      4'd1: r = a - b;
      4'd2: begin
        r[0] = (a == b);
        r[1] = ($signed(a) < $signed(b));
        r[2] = ($signed(a) > $signed(b));
        r[3] = (a < b);
        r[4] = (a > b);
      end
      4'd3: r = a & b;
      4'd4: r = a | b;
      4'd5: r = a ^ b;
      4'd6: r = ~(a | b);
      4'd7: r = a << s;
      4'd8: r = a >> s;
      4'd9: r = $unsigned($signed(a) >>> s);
      4'd10: r = (s == 0) ? a : ((a << s) | (a >> (32 - s)));
      4'd11: begin
        int n;
        n = 32;
        for (int i = 31; i >= 0; i--) if (a[i] && n == 32) n = 31 - i;
        r = XW'(n);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_req(input logic [3:0] o);
    if (o <= 4'd2) return "R5";
    if (o <= 4'd6) return "R6";
    if (o <= 4'd10) return "R7";
    return "R8";
  endfunction

  always @(posedge clk) begin
    for (int v = 0; v < 2; v++) begin
      if (!rst_n) begin
        m_busy[v] = 0; m_ardy[v] = 0; m_brdy[v] = 0; m_snp[v] = 0;
        m_op[v] = '0; m_dst[v] = '0; m_atag[v] = '0; m_btag[v] = '0; m_a[v] = '0; m_b[v] = '0;
        e_rv[v] = 0; e_ill[v] = 0; e_md[v] = 0; e_mdd[v] = 0;
        e_tag[v] = '0; e_val[v] = '0; e_mda[v] = '0; e_mdb[v] = '0;
        e_req[v] = "R1"; e_ill_req[v] = "R1"; done_cnt[v] = 0;
      end else begin
        logic [XW:0] lk;
        e_rv[v] = 0; e_ill[v] = 0; e_md[v] = 0;
        if (m_busy[v]) begin
          if (m_ardy[v] && m_brdy[v]) begin
            m_busy[v] = 0;
            if (m_op[v] == 4'd12 || m_op[v] == 4'd13) begin
              e_md[v] = 1; e_mdd[v] = (m_op[v] == 4'd13);
              e_mda[v] = m_a[v]; e_mdb[v] = m_b[v]; e_tag[v] = m_dst[v];
            end else begin
              e_rv[v] = 1; e_tag[v] = m_dst[v];
              e_val[v] = ref_exec(m_op[v], m_a[v], m_b[v]);
              e_req[v] = m_snp[v] ? "R3" : op_req(m_op[v]);
            end
          end else begin
            if (!m_ardy[v]) begin
              lk = look(m_atag[v]);
              if (lk[XW]) begin m_ardy[v] = 1; m_a[v] = lk[XW-1:0]; m_snp[v] = 1; end
            end
            if (!m_brdy[v]) begin
              lk = look(m_btag[v]);
              if (lk[XW]) begin m_brdy[v] = 1; m_b[v] = lk[XW-1:0]; m_snp[v] = 1; end
            end
          end
        end else if (dv[v]) begin
          done_cnt[v]++;
          if (op >= 4'd14 || ((op == 4'd12 || op == 4'd13) && v == 1)) begin
            e_ill[v] = 1;
            e_ill_req[v] = (op >= 4'd14) ? "R11" : "R9";
          end else begin
            m_busy[v] = 1; m_op[v] = op; m_dst[v] = dst; m_snp[v] = 0;
            m_atag[v] = atag; m_btag[v] = btag;
            if (ardy) begin m_ardy[v] = 1; m_a[v] = aval; end
            else begin
              lk = look(atag); m_ardy[v] = lk[XW]; m_a[v] = lk[XW-1:0];
              if (lk[XW]) m_snp[v] = 1;
            end
            if (brdy) begin m_brdy[v] = 1; m_b[v] = bval; end
            else begin
              lk = look(btag); m_brdy[v] = lk[XW]; m_b[v] = lk[XW-1:0];
              if (lk[XW]) m_snp[v] = 1;
            end
          end
        end
      end
    end
  end

  // ---------------- comparison, every cycle ----------------
  task automatic chk(input logic [XW-1:0] act, input logic [XW-1:0] exp, input string req, input int v, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s dut%0d %s act=%h exp=%h t=%0t", req, v, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!ended) begin
      for (int v = 0; v < 2; v++) begin
        string rq;
        rq = rst_n ? "R2" : "R1";
        chk(XW'(rdy[v]), XW'(!m_busy[v]), rq, v, "ready");
        chk(XW'(ill[v]), XW'(e_ill[v]), rst_n ? e_ill_req[v] : "R1", v, "illegal");
        chk(XW'(mdv[v]), XW'(e_md[v]), rst_n ? "R10" : "R1", v, "md_valid");
        chk(XW'(rv[v]), XW'(e_rv[v]), rst_n ? "R4" : "R1", v, "res_valid");
        if (e_rv[v] && rst_n) begin
          chk(XW'(rtag[v]), XW'(e_tag[v]), "R4", v, "res_tag");
          chk(rval[v], e_val[v], e_req[v], v, "res_val");
        end
        if (e_md[v] && rst_n) begin
          chk(XW'(mdt[v]), XW'(e_tag[v]), "R10", v, "md_tag");
          chk(XW'(mdd[v]), XW'(e_mdd[v]), "R10", v, "md_div");
          chk(mda[v], e_mda[v], "R10", v, "md_a");
          chk(mdb[v], e_mdb[v], "R10", v, "md_b");
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic finish_run;
    if (!ended) begin
      ended = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic rand_snoop;
    for (int i = 0; i < NB; i++) begin
      snp_v[i] = $urandom_range(0, 1) == 1;
      snp_tag[i*TW +: TW] = TW'($urandom_range(0, 3));
      snp_val[i*XW +: XW] = $urandom;
    end
  endtask

  task automatic issue_one(input logic [3:0] o, input logic [TW-1:0] d,
                           input logic ar, input logic [TW-1:0] at, input logic [XW-1:0] av,
                           input logic br, input logic [TW-1:0] bt, input logic [XW-1:0] bv,
                           input bit rnd);
    int s0, s1;
    s0 = done_cnt[0]; s1 = done_cnt[1];
    op = o; dst = d; ardy = ar; atag = at; aval = av; brdy = br; btag = bt; bval = bv;
    dv = 2'b11;
    do begin
      if (rnd) rand_snoop();
      @(negedge clk);
      if (done_cnt[0] != s0) dv[0] = 1'b0;
      if (done_cnt[1] != s1) dv[1] = 1'b0;
    end while (dv != 2'b00 || (rnd && (m_busy[0] || m_busy[1])));
    if (rnd) snp_v = '0;
  endtask

  task automatic drain;
    repeat (3) @(negedge clk);
  endtask

  logic [XW-1:0] pa [6];
  logic [XW-1:0] pb [6];

  initial begin
    pa[0] = 32'h0000_0005; pb[0] = 32'h0000_0003;
    pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
    pa[2] = 32'h8000_0000; pb[2] = 32'h0000_001F;
    pa[3] = 32'h0000_0000; pb[3] = 32'h0000_0000;
    pa[4] = 32'h1234_5678; pb[4] = 32'h8000_0024;
    pa[5] = 32'h0001_F000; pb[5] = 32'h0001_F000;

    #2 rst_n = 1'b0;   // R1: reset state compared each cycle
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5..R8: every computing opcode over several operand patterns
    for (int p = 0; p < 6; p++)
      for (int o = 0; o < 12; o++) begin
        issue_one(4'(o), TW'(o + p), 1, '0, pa[p], 1, '0, pb[p], 0);
        drain();
      end

    // R3: late broadcast on bus 1, unrelated tag on bus 0, b via bus 0 earlier
    issue_one(4'd0, 6'd40, 0, 6'd7, '0, 0, 6'd8, '0, 0);
    @(negedge clk);
    snp_v = 2'b01; snp_tag = {6'd0, 6'd3}; snp_val = {32'h0, 32'hDEAD_0000};
    @(negedge clk);
    snp_v = 2'b01; snp_tag = {6'd0, 6'd8}; snp_val = {32'h0, 32'h0000_0100};
    @(negedge clk);
    snp_v = 2'b00;
    repeat (2) @(negedge clk);
    snp_v = 2'b10; snp_tag = {6'd7, 6'd0}; snp_val = {32'h0000_0023, 32'h0};
    @(negedge clk);
    snp_v = 2'b00;
    drain();

    // R3: broadcast in the dispatch cycle
    snp_v = 2'b01; snp_tag = {6'd0, 6'd9}; snp_val = {32'h0, 32'hF0F0_F0F0};
    fork
      issue_one(4'd5, 6'd41, 0, 6'd9, '0, 1, '0, 32'h0FF0_0FF0, 0);
      begin @(negedge clk); snp_v = 2'b00; end
    join
    drain();

    // R3: both buses match, lowest index wins; ready b ignores matching bus
    snp_v = 2'b11; snp_tag = {6'd11, 6'd11}; snp_val = {32'h2222_2222, 32'h1111_1111};
    fork
      issue_one(4'd0, 6'd42, 0, 6'd11, '0, 1, 6'd11, 32'h0000_0001, 0);
      begin @(negedge clk); snp_v = 2'b00; end
    join
    drain();

    // R2: second dispatch held while the first waits, taken after issue
    issue_one(4'd4, 6'd43, 0, 6'd20, '0, 1, '0, 32'h0000_00F0, 0);
    fork
      issue_one(4'd1, 6'd44, 1, '0, 32'h0000_0010, 1, '0, 32'h0000_0011, 0);
      begin
        repeat (3) @(negedge clk);
        snp_v = 2'b01; snp_tag = {6'd0, 6'd20}; snp_val = {32'h0, 32'h0000_000F};
        @(negedge clk);
        snp_v = 2'b00;
      end
    join
    drain();

    // R10 / R9: multiply and divide
    issue_one(4'd12, 6'd50, 1, '0, 32'h0000_0007, 1, '0, 32'h0000_0009, 0);
    drain();
    issue_one(4'd13, 6'd51, 1, '0, 32'h0000_0040, 1, '0, 32'h0000_0004, 0);
    drain();

    // R11: undefined codes
    issue_one(4'd14, 6'd52, 1, '0, 32'h1, 1, '0, 32'h2, 0);
    drain();
    issue_one(4'd15, 6'd53, 1, '0, 32'h1, 1, '0, 32'h2, 0);
    drain();

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      issue_one(4'($urandom_range(0, 15)), TW'($urandom), $urandom_range(0, 1) == 1,
                TW'($urandom_range(0, 3)), $urandom, $urandom_range(0, 1) == 1,
                TW'($urandom_range(0, 3)), $urandom, 1);
    end
    drain();
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL R4 watchdog act=running exp=finished");
      finish_run();
    end
  end

endmodule